// File: doc/BRIEF.md
# Dual-Version Transactional Line Buffer

A small, fully associative buffer that sits next to an L1 data cache. It holds lines that up to four hardware contexts touch while they run transactions. Every entry keeps two copies of its data word: the committed value, and a speculative value that only the writing context sees. It also keeps one read bit and one write bit per context. Local requests carry a context number and a transactional flag. The buffer compares them with the per-context bits. When a request conflicts, the buffer aborts every other context that holds the line, so the requester always wins. A remote snoop port models coherence traffic from other cores. A miss is filled in the same cycle from a simple fill input that models the next level of memory.

Commit and abort act on one context at a time. An abort is applied to all entries in one cycle. It discards the speculative copies that context wrote and clears its bits. A commit walks the entries one per cycle and clears that context's bits. While the walk runs, the buffer accepts no request of any kind, so other agents see the commit as a single step. An abort raised by the buffer itself is reported on a per-context pulse vector with a two-bit cause. If no entry can be replaced because every entry is pinned by a transaction, the requester is aborted with a resource cause.

Top module: `dual_ver_linebuf`

## Requirements
- R1: After reset no entry is valid, `req_ready`, `snp_ready` and `ctl_ready` are high, and `resp_valid`, `abort_vec` and `abort_cause` are zero.
- R2: An accepted request completes one cycle later with `resp_valid` high. A read returns the buffered value on a hit and `fill_data` on a miss. A write returns its own write data.
- R3: A context's first speculative write to a line leaves the committed value in place and puts the data in the speculative copy. Later reads and writes by that context use the speculative copy.
- R4: Aborting a context clears its read and write bits in every entry and drops its speculative copies, so later reads return the committed value. Lines it only read stay in the buffer.
- R5: A commit keeps `req_ready`, `snp_ready` and `ctl_ready` low for exactly NENT cycles after it is accepted. Afterwards the committed context's speculative values are the committed values, and other contexts read them with no abort.
- R6: A speculative write to a line whose committed value lives in the speculative copy first moves that value into the committed copy. A later abort of the writer therefore returns it.
- R7: A write (speculative or not) to a line that another context has read or written speculatively aborts that context with cause 01 (conflict).
- R8: A read of a line that another context has written speculatively aborts the writer with cause 01 and returns the committed value.
- R9: A non-transactional access that conflicts with a transaction aborts the transaction under the rules of R7 and R8.
- R10: A remote snoop write aborts every context with a bit set on the line and invalidates the line. A remote snoop read aborts only the writer. A snoop produces no `resp_valid`.
- R11: A miss fills the lowest-numbered invalid entry. If there is none, it replaces the least recently requested entry among those with no read or write bit set.
- R12: If every entry has a read or write bit set, a missing request is not performed: there is no `resp_valid`, and the requester is aborted with cause 10 (resource).
- R13: Aborts raised by the buffer appear one cycle after the triggering request or snoop, as `abort_vec` bit c together with the code in `abort_cause[2c+1:2c]` (00 none, 01 conflict, 10 resource). Both last one cycle. An abort issued through the control port raises no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Local request present |
| req_ctx | input | 2 | Requesting hardware context |
| req_write | input | 1 | 1 = write, 0 = read |
| req_spec | input | 1 | 1 = transactional (speculative) access |
| req_tag | input | TAG_W | Line tag |
| req_wdata | input | DATA_W | Write data |
| fill_data | input | DATA_W | Line value from the next level for `req_tag` |
| req_ready | output | 1 | Request accepted this cycle when valid |
| resp_valid | output | 1 | Request completed |
| resp_data | output | DATA_W | Read value, or the written value for writes |
| snp_valid | input | 1 | Remote snoop present |
| snp_write | input | 1 | 1 = remote write, 0 = remote read |
| snp_tag | input | TAG_W | Snooped line tag |
| snp_ready | output | 1 | Snoop accepted when valid |
| ctl_valid | input | 1 | Commit or abort command present |
| ctl_commit | input | 1 | 1 = commit, 0 = abort |
| ctl_ctx | input | 2 | Context to commit or abort |
| ctl_ready | output | 1 | Command accepted when valid |
| abort_vec | output | NCTX | One-cycle abort pulse per context |
| abort_cause | output | 2*NCTX | Abort cause per context |

## Verification
The bench goes after the same-cycle cases: a request hits a line whose writer it is aborting, or a speculative write lands on a line whose committed value sits in the speculative copy. A design that read the pre-abort state would return discarded data. A design that skipped the copy from New to Old would lose the committed value when the second writer aborts. Replacement is checked with every entry pinned and with a recency order changed by touching one entry. A design that evicted a pinned line would silently break a transaction, and one that ignored recency would evict a recently touched line. The commit walk is timed cycle by cycle, because releasing the stall one cycle early would let a request see a half-committed buffer.

// File: rtl/dual_ver_linebuf.sv
module dual_ver_linebuf #(
  parameter int NCTX   = 4,
  parameter int NENT   = 8,
  parameter int TAG_W  = 16,
  parameter int DATA_W = 64,
  localparam int CW = (NCTX > 1) ? $clog2(NCTX) : 1,
  localparam int EW = (NENT > 1) ? $clog2(NENT) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [CW-1:0]        req_ctx,
  input  logic                 req_write,
  input  logic                 req_spec,
  input  logic [TAG_W-1:0]     req_tag,
  input  logic [DATA_W-1:0]    req_wdata,
  input  logic [DATA_W-1:0]    fill_data,
  output logic                 req_ready,
  output logic                 resp_valid,
  output logic [DATA_W-1:0]    resp_data,
  input  logic                 snp_valid,
  input  logic                 snp_write,
  input  logic [TAG_W-1:0]     snp_tag,
  output logic                 snp_ready,
  input  logic                 ctl_valid,
  input  logic                 ctl_commit,
  input  logic [CW-1:0]        ctl_ctx,
  output logic                 ctl_ready,
  output logic [NCTX-1:0]      abort_vec,
  output logic [2*NCTX-1:0]    abort_cause
);

  logic [NENT-1:0]             v_q, v_d, cn_q, cn_d;
  logic [NENT-1:0][TAG_W-1:0]  tag_q, tag_d;
  logic [NENT-1:0][DATA_W-1:0] old_q, old_d, new_q, new_d;
  logic [NENT-1:0][NCTX-1:0]   rv_q, rv_d, wv_q, wv_d;
  logic [NENT-1:0][EW-1:0]     age_q, age_d;
  logic                        busy_q;
  logic [EW-1:0]               idx_q;
  logic [CW-1:0]               cctx_q;

  assign req_ready = !busy_q && !snp_valid && !ctl_valid;
  assign snp_ready = !busy_q;
  assign ctl_ready = !busy_q && !snp_valid;

  logic req_go, snp_go, ctl_go;
  assign req_go = req_valid && req_ready;
  assign snp_go = snp_valid && snp_ready;
  assign ctl_go = ctl_valid && ctl_ready;

  logic          hit, shit, free_ok, got_inv;
  logic [EW-1:0] hidx, sidx, fidx, best;

  always_comb begin
    hit = 1'b0; hidx = '0; shit = 1'b0; sidx = '0;
    for (int e = 0; e < NENT; e++) begin
      if (v_q[e] && tag_q[e] == req_tag) begin hit = 1'b1; hidx = EW'(e); end
      if (v_q[e] && tag_q[e] == snp_tag) begin shit = 1'b1; sidx = EW'(e); end
    end
  end

  always_comb begin
    free_ok = 1'b0; fidx = '0; got_inv = 1'b0; best = '0;
    for (int e = 0; e < NENT; e++)
      if (!v_q[e] && !got_inv) begin got_inv = 1'b1; free_ok = 1'b1; fidx = EW'(e); end
    if (!got_inv)
      for (int e = 0; e < NENT; e++)
        if (rv_q[e] == '0 && wv_q[e] == '0 && (!free_ok || age_q[e] > best)) begin
          free_ok = 1'b1; fidx = EW'(e); best = age_q[e];
        end
  end

  logic [NCTX-1:0] self_m, conf_k, snp_k, res_k, ctl_k, kill;
  logic            acc_go;
  logic [EW-1:0]   aidx;

  assign self_m = NCTX'(1) << req_ctx;
  assign conf_k = (req_go && hit) ?
                  ((req_write ? (rv_q[hidx] | wv_q[hidx]) : wv_q[hidx]) & ~self_m) : '0;
  assign snp_k  = (snp_go && shit) ? (snp_write ? (rv_q[sidx] | wv_q[sidx]) : wv_q[sidx]) : '0;
  assign res_k  = (req_go && !hit && !free_ok) ? self_m : '0;
  assign ctl_k  = (ctl_go && !ctl_commit) ? (NCTX'(1) << ctl_ctx) : '0;
  assign kill   = conf_k | snp_k | res_k | ctl_k;
  assign acc_go = req_go && (hit || free_ok);
  assign aidx   = hit ? hidx : fidx;

  logic [DATA_W-1:0] rd_data;

  always_comb begin
    v_d = v_q; tag_d = tag_q; old_d = old_q; new_d = new_q; cn_d = cn_q; age_d = age_q;
    rd_data = fill_data;
    for (int e = 0; e < NENT; e++) begin
      if (|(wv_q[e] & kill)) cn_d[e] = 1'b0;
      rv_d[e] = rv_q[e] & ~kill;
      wv_d[e] = wv_q[e] & ~kill;
      if (snp_go && shit && snp_write && sidx == EW'(e)) v_d[e] = 1'b0;
      if (busy_q && idx_q == EW'(e)) begin
        rv_d[e][cctx_q] = 1'b0;
        wv_d[e][cctx_q] = 1'b0;
      end
    end
    if (acc_go) begin
      if (!hit) begin
        v_d[aidx] = 1'b1; tag_d[aidx] = req_tag; old_d[aidx] = fill_data;
        cn_d[aidx] = 1'b0; rv_d[aidx] = '0; wv_d[aidx] = '0;
      end
      rd_data = (wv_d[aidx][req_ctx] || cn_d[aidx]) ? new_d[aidx] : old_d[aidx];
      if (req_write && req_spec) begin
        if (!wv_d[aidx][req_ctx]) begin
          if (cn_d[aidx]) old_d[aidx] = new_d[aidx];
          cn_d[aidx] = 1'b1;
        end
        new_d[aidx] = req_wdata;
        wv_d[aidx][req_ctx] = 1'b1;
      end else if (req_write) begin
        old_d[aidx] = req_wdata;
        cn_d[aidx]  = 1'b0;
      end else if (req_spec) begin
        rv_d[aidx][req_ctx] = 1'b1;
      end
      for (int e = 0; e < NENT; e++)
        if (EW'(e) == aidx)           age_d[e] = '0;
        else if (age_q[e] < age_q[aidx]) age_d[e] = age_q[e] + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q <= '0; cn_q <= '0; rv_q <= '0; wv_q <= '0;
      tag_q <= '0; old_q <= '0; new_q <= '0;
      for (int e = 0; e < NENT; e++) age_q[e] <= EW'(e);
      busy_q <= 1'b0; idx_q <= '0; cctx_q <= '0;
      resp_valid <= 1'b0; resp_data <= '0;
      abort_vec <= '0; abort_cause <= '0;
    end else begin
      v_q <= v_d; cn_q <= cn_d; rv_q <= rv_d; wv_q <= wv_d;
      tag_q <= tag_d; old_q <= old_d; new_q <= new_d; age_q <= age_d;
      if (ctl_go && ctl_commit) begin
        busy_q <= 1'b1; idx_q <= '0; cctx_q <= ctl_ctx;
      end else if (busy_q) begin
        idx_q <= idx_q + 1'b1;
        if (idx_q == EW'(NENT - 1)) busy_q <= 1'b0;
      end
      resp_valid <= acc_go;
      resp_data  <= req_write ? req_wdata : rd_data;
      abort_vec  <= conf_k | snp_k | res_k;
      for (int c = 0; c < NCTX; c++)
        abort_cause[2*c +: 2] <= res_k[c] ? 2'b10 : ((conf_k[c] | snp_k[c]) ? 2'b01 : 2'b00);
    end
  end

endmodule

// File: rtl/dual_ver_linebuf_chk.sv
module dual_ver_linebuf_chk #(
  parameter int NCTX = 4,
  parameter int NENT = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      req_valid,
  input logic                      req_ready,
  input logic                      snp_valid,
  input logic                      snp_ready,
  input logic                      ctl_valid,
  input logic                      ctl_ready,
  input logic                      ctl_commit,
  input logic                      resp_valid,
  input logic [NCTX-1:0]           abort_vec,
  input logic [2*NCTX-1:0]         abort_cause,
  input logic [NENT-1:0]           v,
  input logic [NENT-1:0][NCTX-1:0] wv
);

  a_r2_resp_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $past(req_valid && req_ready));

  a_r5_commit_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_valid && ctl_ready && ctl_commit) |=> (!req_ready && !snp_ready && !ctl_ready));

  a_r10_snoop_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_ready) |=> !resp_valid);

  genvar g;
  generate
    for (g = 0; g < NCTX; g++) begin : g_ctx
      a_r13_cause_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        abort_vec[g] |-> (abort_cause[2*g +: 2] == 2'b01 || abort_cause[2*g +: 2] == 2'b10));
      a_r13_no_cause_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !abort_vec[g] |-> abort_cause[2*g +: 2] == 2'b00);
      a_r12_resource_no_resp: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_cause[2*g +: 2] == 2'b10) |-> !resp_valid);
    end
    for (g = 0; g < NENT; g++) begin : g_ent
      a_r7_single_writer: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wv[g]));
      a_r10_writer_on_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (wv[g] != '0) |-> v[g]);
    end
  endgenerate

endmodule

bind dual_ver_linebuf dual_ver_linebuf_chk #(.NCTX(NCTX), .NENT(NENT)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .snp_valid(snp_valid), .snp_ready(snp_ready), .ctl_valid(ctl_valid),
  .ctl_ready(ctl_ready), .ctl_commit(ctl_commit), .resp_valid(resp_valid),
  .abort_vec(abort_vec), .abort_cause(abort_cause), .v(v_q), .wv(wv_q)
);

// File: tb/dual_ver_linebuf_bench.sv
module dual_ver_linebuf_bench;
  localparam int NCTX = 4, NENT = 8, TW = 16, DW = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          req_valid = 0, req_write = 0, req_spec = 0;
  logic [1:0]    req_ctx = 0;
  logic [TW-1:0] req_tag = 0;
  logic [DW-1:0] req_wdata = 0, fill_data, resp_data;
  logic          req_ready, resp_valid, snp_ready, ctl_ready;
  logic          snp_valid = 0, snp_write = 0, ctl_valid = 0, ctl_commit = 0;
  logic [TW-1:0] snp_tag = 0;
  logic [1:0]    ctl_ctx = 0;
  logic [NCTX-1:0]   abort_vec;
  logic [2*NCTX-1:0] abort_cause;

  function automatic logic [DW-1:0] fillfn(logic [TW-1:0] t);
    return {t, ~t, t ^ 16'h5a5a, t + 16'h1234};
  endfunction
  assign fill_data = fillfn(req_tag);

  dual_ver_linebuf u_dual_ver_linebuf (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ctx(req_ctx),
    .req_write(req_write), .req_spec(req_spec), .req_tag(req_tag),
    .req_wdata(req_wdata), .fill_data(fill_data), .req_ready(req_ready),
    .resp_valid(resp_valid), .resp_data(resp_data), .snp_valid(snp_valid),
    .snp_write(snp_write), .snp_tag(snp_tag), .snp_ready(snp_ready),
    .ctl_valid(ctl_valid), .ctl_commit(ctl_commit), .ctl_ctx(ctl_ctx),
    .ctl_ready(ctl_ready), .abort_vec(abort_vec), .abort_cause(abort_cause));

  int checks = 0, errors = 0, cyc = 0;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(bit ok, string rq, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // reference model of the requirements
  bit            m_v[NENT], m_cn[NENT];
  logic [TW-1:0] m_tag[NENT];
  logic [DW-1:0] m_old[NENT], m_new[NENT];
  logic [NCTX-1:0] m_rv[NENT], m_wv[NENT];
  int            m_st[NENT];
  int            now = 0;

  task automatic m_kill(logic [NCTX-1:0] k);
    for (int e = 0; e < NENT; e++) begin
      if ((m_wv[e] & k) != 0) m_cn[e] = 0;
      m_rv[e] &= ~k;
      m_wv[e] &= ~k;
    end
  endtask

  function automatic logic [2*NCTX-1:0] causes(logic [NCTX-1:0] k, logic [1:0] code);
    logic [2*NCTX-1:0] r = '0;
    for (int c = 0; c < NCTX; c++) if (k[c]) r[2*c +: 2] = code;
    return r;
  endfunction

  task automatic do_req(int c, bit wr, bit sp, logic [TW-1:0] tg, logic [DW-1:0] wd,
                        string rq, output logic [DW-1:0] got, output logic [NCTX-1:0] gav);
    int hitx = -1, idx = -1;
    logic [NCTX-1:0] k = '0, self = NCTX'(1) << c;
    logic [2*NCTX-1:0] ec = '0;
    logic [DW-1:0] ed = '0;
    bit ev = 0;
    for (int e = 0; e < NENT; e++) if (m_v[e] && m_tag[e] == tg) hitx = e;
    if (hitx >= 0) begin
      idx = hitx;
      k = (wr ? (m_rv[idx] | m_wv[idx]) : m_wv[idx]) & ~self;
      ec = causes(k, 2'b01);
    end else begin
      for (int e = NENT - 1; e >= 0; e--) if (!m_v[e]) idx = e;
      if (idx < 0)
        for (int e = 0; e < NENT; e++)
          if (m_rv[e] == 0 && m_wv[e] == 0 && (idx < 0 || m_st[e] < m_st[idx])) idx = e;
      if (idx < 0) begin k = self; ec = causes(k, 2'b10); end
    end
    m_kill(k);
    if (idx >= 0) begin
      if (hitx < 0) begin
        m_v[idx] = 1; m_tag[idx] = tg; m_old[idx] = fillfn(tg);
        m_cn[idx] = 0; m_rv[idx] = 0; m_wv[idx] = 0;
      end
      ed = (m_wv[idx][c] || m_cn[idx]) ? m_new[idx] : m_old[idx];
      if (wr && sp) begin
        if (!m_wv[idx][c]) begin
          if (m_cn[idx]) m_old[idx] = m_new[idx];
          m_cn[idx] = 1;
        end
        m_new[idx] = wd; m_wv[idx][c] = 1'b1;
      end else if (wr) begin
        m_old[idx] = wd; m_cn[idx] = 0;
      end else if (sp) m_rv[idx][c] = 1'b1;
      now++; m_st[idx] = now;
      ev = 1;
      if (wr) ed = wd;
    end
    req_valid = 1; req_ctx = 2'(c); req_write = wr; req_spec = sp;
    req_tag = tg; req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
    got = resp_data; gav = abort_vec;
    chk(resp_valid == ev, {rq, " resp_valid"}, 64'(resp_valid), 64'(ev));
    if (ev) chk(resp_data == ed, {rq, " resp_data"}, resp_data, ed);
    chk(abort_vec == k, {rq, " abort_vec"}, 64'(abort_vec), 64'(k));
    chk(abort_cause == ec, {rq, " abort_cause"}, 64'(abort_cause), 64'(ec));
  endtask

  task automatic do_snp(bit wr, logic [TW-1:0] tg, string rq, output logic [NCTX-1:0] gav);
    logic [NCTX-1:0] k = '0;
    for (int e = 0; e < NENT; e++)
      if (m_v[e] && m_tag[e] == tg) begin
        k = wr ? (m_rv[e] | m_wv[e]) : m_wv[e];
        m_kill(k);
        if (wr) m_v[e] = 0;
      end
    snp_valid = 1; snp_write = wr; snp_tag = tg;
    @(negedge clk);
    snp_valid = 0;
    gav = abort_vec;
    chk(!resp_valid, {rq, " snoop resp"}, 64'(resp_valid), 64'(0));
    chk(abort_vec == k, {rq, " snoop abort_vec"}, 64'(abort_vec), 64'(k));
    chk(abort_cause == causes(k, 2'b01), {rq, " snoop cause"}, 64'(abort_cause),
        64'(causes(k, 2'b01)));
  endtask

  task automatic do_abort(int c);
    m_kill(NCTX'(1) << c);
    ctl_valid = 1; ctl_commit = 0; ctl_ctx = 2'(c);
    @(negedge clk);
    ctl_valid = 0;
    chk(abort_vec == 0, "R13 control abort no pulse", 64'(abort_vec), 64'(0));
  endtask

  task automatic do_commit(int c);
    for (int e = 0; e < NENT; e++) begin
      m_rv[e][c] = 1'b0; m_wv[e][c] = 1'b0;
    end
    ctl_valid = 1; ctl_commit = 1; ctl_ctx = 2'(c);
    for (int i = 0; i < NENT; i++) begin
      @(negedge clk);
      ctl_valid = 0;
      chk(!req_ready && !snp_ready && !ctl_ready, "R5 stall during commit",
          64'({req_ready, snp_ready, ctl_ready}), 64'(0));
    end
    @(negedge clk);
    chk(req_ready && snp_ready && ctl_ready, "R5 ready after commit",
        64'({req_ready, snp_ready, ctl_ready}), 64'(7));
  endtask

  logic [DW-1:0]   g;
  logic [NCTX-1:0] av;

  initial begin
    for (int e = 0; e < NENT; e++) begin
      m_v[e] = 0; m_cn[e] = 0; m_rv[e] = 0; m_wv[e] = 0; m_st[e] = 0;
      m_tag[e] = 0; m_old[e] = 0; m_new[e] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && snp_ready && ctl_ready, "R1 ready after reset",
        64'({req_ready, snp_ready, ctl_ready}), 64'(7));
    chk(!resp_valid, "R1 resp_valid reset", 64'(resp_valid), 64'(0));
    chk(abort_vec == 0 && abort_cause == 0, "R1 abort outputs reset",
        64'({abort_vec, abort_cause}), 64'(0));

    do_req(0, 0, 0, 16'd5, 0, "R1 R2 miss", g, av);
    chk(g == fillfn(16'd5), "R2 miss fill", g, fillfn(16'd5));
    do_req(0, 1, 0, 16'd5, 64'hA, "R2 write", g, av);
    do_req(1, 0, 1, 16'd5, 0, "R2 hit", g, av);
    chk(g == 64'hA, "R2 hit data", g, 64'hA);
    do_req(0, 1, 1, 16'd5, 64'hB, "R7 write conflict", g, av);
    chk(av == 4'b0010 && abort_cause == 8'h04, "R7 reader aborted", 64'({av, abort_cause}), 64'h204);
    do_req(0, 0, 1, 16'd5, 0, "R3 own copy", g, av);
    chk(g == 64'hB, "R3 writer reads speculative", g, 64'hB);
    chk(av == 0, "R13 pulse lasts one cycle", 64'(av), 64'(0));
    do_req(2, 0, 0, 16'd5, 0, "R8 R9 read conflict", g, av);
    chk(g == 64'hA && av == 4'b0001, "R8 R9 writer aborted, old value", g, 64'hA);
    do_req(2, 0, 0, 16'd5, 0, "R4 after abort", g, av);
    chk(g == 64'hA && av == 0, "R4 bits cleared", g, 64'hA);

    do_req(3, 1, 1, 16'd5, 64'hC, "R5 spec write", g, av);
    do_commit(3);
    do_req(1, 0, 0, 16'd5, 0, "R5 after commit", g, av);
    chk(g == 64'hC && av == 0, "R5 committed value visible", g, 64'hC);
    do_req(1, 1, 1, 16'd5, 64'hD, "R6 write dirty line", g, av);
    do_req(1, 0, 1, 16'd5, 0, "R6 own read", g, av);
    chk(g == 64'hD, "R6 writer sees new", g, 64'hD);
    do_abort(1);
    do_req(2, 0, 0, 16'd5, 0, "R6 R4 after abort", g, av);
    chk(g == 64'hC, "R6 committed copy kept", g, 64'hC);

    do_req(2, 0, 1, 16'd5, 0, "R10 setup read", g, av);
    do_req(3, 1, 1, 16'd6, 64'hE, "R10 setup write", g, av);
    do_snp(0, 16'd5, "R10 snoop read reader", av);
    chk(av == 0, "R10 snoop read spares reader", 64'(av), 64'(0));
    do_snp(0, 16'd6, "R10 snoop read writer", av);
    chk(av == 4'b1000, "R10 snoop read aborts writer", 64'(av), 64'h8);
    do_snp(1, 16'd5, "R10 snoop write", av);
    chk(av == 4'b0100, "R10 snoop write aborts reader", 64'(av), 64'h4);
    do_req(0, 0, 0, 16'd5, 0, "R10 line dropped", g, av);
    chk(g == fillfn(16'd5), "R10 refetched after snoop write", g, fillfn(16'd5));

    for (int i = 0; i < NENT; i++) do_req(0, 0, 1, TW'(20 + i), 0, "R11 pin fill", g, av);
    do_req(1, 0, 0, 16'd30, 0, "R12 all pinned", g, av);
    chk(av == 4'b0010 && abort_cause == 8'h08, "R12 resource abort", 64'({av, abort_cause}), 64'h208);
    do_abort(0);

    for (int i = 0; i < NENT; i++) do_req(2, 1, 0, TW'(20 + i), 64'(256 + i), "R11 writes", g, av);
    do_req(2, 0, 0, 16'd20, 0, "R11 touch", g, av);
    do_req(2, 0, 0, 16'd31, 0, "R11 miss", g, av);
    do_req(2, 0, 0, 16'd20, 0, "R11 recent kept", g, av);
    chk(g == 64'd256, "R11 touched line kept", g, 64'd256);
    do_req(2, 0, 0, 16'd21, 0, "R11 oldest evicted", g, av);
    chk(g == fillfn(16'd21), "R11 oldest replaced", g, fillfn(16'd21));

    void'($urandom(32'd2024));
    for (int n = 0; n < 4000; n++) begin
      int r = $urandom_range(0, 99);
      if (r < 70)
        do_req($urandom_range(0, 3), 1'($urandom_range(0, 1)), ($urandom_range(0, 3) != 0),
               TW'(40 + $urandom_range(0, 11)), {$urandom, $urandom}, "R2/R3/R7/R8/R11/R12", g, av);
      else if (r < 80)
        do_snp(1'($urandom_range(0, 1)), TW'(40 + $urandom_range(0, 11)), "R10", av);
      else if (r < 90)
        do_abort($urandom_range(0, 3));
      else
        do_commit($urandom_range(0, 3));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule